// File: doc/BRIEF.md
# Branch Direction Predictor

This block guesses whether a conditional branch in the fetch stage will be taken. The fetch stage presents the branch PC and the sign of its offset, and a one-bit guess comes back in the same cycle. Later, the execute stage reports the resolved direction together with the PC of that branch, and the block trains its state.

A two-bit mode input chooses the policy at run time. Three policies are static: always taken, always not-taken, and a sign-based policy that predicts backward branches taken and forward branches not-taken. The fourth policy is dynamic. It reads a table of saturating counters, `2^IDX_W` entries of `CNT_W` bits each. The table is indexed by the PC bits just above the word-alignment bits and carries no tag, so branches that share those bits share an entry. Setting `CNT_W` to 1 gives the single-bit scheme, in which each entry simply records the last outcome.

Training happens in every mode, so switching to the dynamic policy keeps what the table has already learned.

Top module: `bp_direction_predictor`

## Requirements
- R1: With `mode_i` = 0, `pred_taken_o` is 1 whatever the PC or the table holds.
- R2: With `mode_i` = 1, `pred_taken_o` is 0 whatever the PC or the table holds.
- R3: With `mode_i` = 2, `pred_taken_o` equals `backward_i`. A value of 1 marks a target below the branch PC.
- R4: With `mode_i` = 3, `pred_taken_o` is the most significant bit of the entry at index `lookup_pc_i[ALIGN_W +: IDX_W]`. After reset, every entry holds 2^(CNT_W-1)-1, which predicts not-taken.
- R5: An accepted update with `upd_taken_i` = 1 raises the addressed entry by one. An entry already at 2^CNT_W-1 stays there.
- R6: An accepted update with `upd_taken_i` = 0 lowers the addressed entry by one. An entry already at 0 stays there.
- R7: With CNT_W = 2, an entry at its top value keeps predicting taken after one not-taken update. It predicts not-taken only after a second one.
- R8: The index ignores the low ALIGN_W PC bits and all bits above ALIGN_W+IDX_W. PCs that agree on the index bits share one entry. An entry at another index is unaffected by updates to this one.
- R9: Updates with `upd_valid_i` = 1 are applied in every mode. A later switch to mode 3 predicts from the state those updates trained.
- R10: The lookup is combinational. If an update addresses the entry being read in the same cycle, the prediction in that cycle comes from the old value, and the new value shows from the next cycle on.
- R11: While `upd_valid_i` is 0, no entry changes, whatever `upd_pc_i` and `upd_taken_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Policy: 0 taken, 1 not-taken, 2 sign-based, 3 counter table |
| lookup_pc_i | input | PC_W | PC of the branch being fetched |
| backward_i | input | 1 | 1 when the branch offset is negative |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | Resolved-outcome strobe |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction, 1 = taken |

## Verification
A prediction depends on its inputs and on the table state in the same cycle, with no register in between. An update becomes visible exactly one clock edge after the cycle in which it was strobed. The bench drives each vector on the falling edge and samples `pred_taken_o` one nanosecond later, before the next rising edge. The sample therefore reflects the table as it stood before that vector's own update, and each vector's expected value accounts for every update applied by the vectors before it. The reset checks sample after reset is released and before any update strobe, so they see the initial table contents.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    BP_ALWAYS_T  = 2'd0,
    BP_ALWAYS_NT = 2'd1,
    BP_SIGN      = 2'd2,
    BP_TABLE     = 2'd3
  } bp_mode_e;
endpackage

// File: rtl/bp_sat_step.sv
module bp_sat_step #(
  parameter int unsigned CNT_W = 2
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             taken_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_comb begin
    cnt_o = cnt_i;
    if (taken_i) begin
      if (cnt_i != CNT_MAX) cnt_o = cnt_i + CNT_ONE;
    end else begin
      if (cnt_i != '0) cnt_o = cnt_i - CNT_ONE;
    end
  end
endmodule

// File: rtl/bp_static_dir.sv
module bp_static_dir
  import bp_pkg::*;
(
  input  bp_mode_e mode_i,
  input  logic     backward_i,
  output logic     dir_o
);
  always_comb begin
    unique case (mode_i)
      BP_ALWAYS_T:  dir_o = 1'b1;
      BP_ALWAYS_NT: dir_o = 1'b0;
      BP_SIGN:      dir_o = backward_i;
      default:      dir_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bp_table.sv
module bp_table #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_cnt_o,
  input  logic             upd_valid_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_taken_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'((1 << (CNT_W - 1)) - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [CNT_W-1:0] upd_old;
  logic [CNT_W-1:0] upd_new;

  assign rd_cnt_o = cnt_q[rd_idx_i];
  assign upd_old  = cnt_q[upd_idx_i];

  bp_sat_step #(.CNT_W(CNT_W)) u_step (
    .cnt_i  (upd_old),
    .taken_i(upd_taken_i),
    .cnt_o  (upd_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= CNT_RST;
    end else if (upd_valid_i) begin
      cnt_q[upd_idx_i] <= upd_new;
    end
  end

  assert_taken_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_taken_i |=>
      cnt_q[$past(upd_idx_i)] >= $past(upd_old));

  assert_taken_sat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_taken_i && upd_old == CNT_MAX |=>
      cnt_q[$past(upd_idx_i)] == CNT_MAX);

  assert_ntaken_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !upd_taken_i |=>
      cnt_q[$past(upd_idx_i)] <= $past(upd_old));

  assert_ntaken_floor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !upd_taken_i && upd_old == '0 |=>
      cnt_q[$past(upd_idx_i)] == '0);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> cnt_q[$past(rd_idx_i)] == $past(rd_cnt_o));
endmodule

// File: rtl/bp_direction_predictor.sv
module bp_direction_predictor
  import bp_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ALIGN_W = 2,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned CNT_W   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  input  logic [PC_W-1:0] lookup_pc_i,
  input  logic            backward_i,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  bp_mode_e         mode;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic [CNT_W-1:0] rd_cnt;
  logic             static_dir;

  assign mode   = bp_mode_e'(mode_i);
  assign rd_idx = lookup_pc_i[ALIGN_W +: IDX_W];
  assign wr_idx = upd_pc_i[ALIGN_W +: IDX_W];

  bp_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_idx),
    .rd_cnt_o   (rd_cnt),
    .upd_valid_i(upd_valid_i),
    .upd_idx_i  (wr_idx),
    .upd_taken_i(upd_taken_i)
  );

  bp_static_dir u_static (
    .mode_i    (mode),
    .backward_i(backward_i),
    .dir_o     (static_dir)
  );

  // counter MSB splits the range into not-taken and taken halves
  assign pred_taken_o = (mode == BP_TABLE) ? rd_cnt[CNT_W-1] : static_dir;

  assert_always_t_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd0 |-> pred_taken_o);

  assert_always_nt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd1 |-> !pred_taken_o);

  assert_sign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd2 |-> pred_taken_o == backward_i);

  assert_same_idx_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i && mode_i == 2'd3 && $past(mode_i) == 2'd3 &&
    $stable(lookup_pc_i) && !$past(upd_valid_i) |-> $stable(pred_taken_o));
endmodule

// File: tb/tb_bp_direction_predictor.sv
`timescale 1ns/1ps
module tb_bp_direction_predictor;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode = 2'd3;
  logic [PC_W-1:0] lpc = '0;
  logic            back = 1'b0;
  logic            pred;
  logic            uv = 1'b0;
  logic [PC_W-1:0] upc = '0;
  logic            ut = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bp_direction_predictor dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .lookup_pc_i(lpc),
    .backward_i(back), .pred_taken_o(pred), .upd_valid_i(uv),
    .upd_pc_i(upc), .upd_taken_i(ut)
  );

  // {mode, pc, back, uv, upc, ut, exp, req}
  localparam int NV = 20;
  localparam logic [41:0] VEC [NV] = '{
    {2'd3, 16'h0104, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd4},
    {2'd3, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b1, 1'b0, 4'd10},
    {2'd3, 16'h0104, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd5},
    {2'd3, 16'h0204, 1'b0, 1'b1, 16'h0104, 1'b1, 1'b1, 4'd8},
    {2'd3, 16'h0107, 1'b0, 1'b1, 16'h0104, 1'b1, 1'b1, 4'd8},
    {2'd3, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b0, 1'b1, 4'd5},
    {2'd3, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b0, 1'b1, 4'd7},
    {2'd3, 16'h0104, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd7},
    {2'd3, 16'h0020, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd8},
    {2'd0, 16'h0020, 1'b0, 1'b1, 16'h0104, 1'b0, 1'b1, 4'd1},
    {2'd1, 16'h0104, 1'b1, 1'b1, 16'h0104, 1'b0, 1'b0, 4'd2},
    {2'd2, 16'h0020, 1'b1, 1'b1, 16'h0020, 1'b1, 1'b1, 4'd3},
    {2'd2, 16'h0020, 1'b0, 1'b1, 16'h0020, 1'b1, 1'b0, 4'd3},
    {2'd3, 16'h0020, 1'b0, 1'b1, 16'h0020, 1'b0, 1'b1, 4'd9},
    {2'd3, 16'h0020, 1'b0, 1'b0, 16'h0020, 1'b0, 1'b1, 4'd11},
    {2'd3, 16'h0020, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd11},
    {2'd3, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b1, 1'b0, 4'd6},
    {2'd3, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b1, 1'b0, 4'd6},
    {2'd3, 16'h0104, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd6},
    {2'd3, 16'h0020, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd9}
  };

  task automatic check(input logic exp, input string req);
    total++;
    if (pred !== exp) begin
      bad++;
      $display("FAIL %s: pred=%0b expected=%0b (mode=%0d pc=%h)", req, pred, exp, mode, lpc);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: every entry starts weakly not-taken
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      mode = 2'd3; lpc = PC_W'(i << 2); uv = 1'b0;
      #1 check(1'b0, "R4 reset state");
    end

    // vector walk: R1 R2 R3 R5 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mode = VEC[v][41:40];
      lpc  = PC_W'(VEC[v][39:24]);
      back = VEC[v][23];
      uv   = VEC[v][22];
      upc  = PC_W'(VEC[v][21:6]);
      ut   = VEC[v][5];
      #1 check(VEC[v][4], $sformatf("R%0d vec%0d", VEC[v][3:0], v));
    end

    // R10: updated value visible the cycle after the write
    @(negedge clk);
    mode = 2'd3; lpc = 32'h0000_0104; uv = 1'b0;
    #1 check(1'b1, "R10 next-cycle visibility");

    // R1 R2 R3: static outputs ignore a trained entry
    @(negedge clk);
    mode = 2'd1; lpc = 32'h0000_0104;
    #1 check(1'b0, "R2 ignores table");
    @(negedge clk);
    mode = 2'd2; back = 1'b0;
    #1 check(1'b0, "R3 forward");
    @(negedge clk);
    mode = 2'd0; lpc = 32'h0000_0040;
    #1 check(1'b1, "R1 untrained entry");

    // R4: reset mid-run restores the initial table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; mode = 2'd3; lpc = 32'h0000_0104;
    #1 check(1'b0, "R4 reset after training");
    @(negedge clk);
    lpc = 32'h0000_0020;
    #1 check(1'b0, "R4 reset second entry");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule